// File: doc/BRIEF.md
# Special Register Move Unit

This unit carries out the two special-register move instructions of a 64-bit fixed-point core. Each cycle it takes one 32-bit instruction word, the 64-bit value of the source general register, and the two state bits for problem state and hypervisor mode. It recognises a move-to or a move-from, rebuilds the special register number from its split encoding, and decides whether the access is allowed, privileged or undefined. A permitted move-to updates one of a small set of special registers on the next rising edge. A permitted move-from returns the register contents in the same cycle.

The registers are a mix of 64-bit and 32-bit widths. Narrow registers keep only the low half of a written value and read back zero-extended. The two 32-bit time base halves are written one at a time. A hypervisor-only register ignores accesses made outside hypervisor mode. Denied accesses report one of two program interrupt flags and change nothing.

The instruction input is a plain qualified stream. There is no back-pressure: every cycle in which `instr_valid` is high is consumed in that cycle, so no ready signal exists. The result and the flags are combinational and belong to the instruction presented in the same cycle.

Top module: `spru_unit`

## Requirements
- R1: An instruction is recognised only when `instr[31:26]` equals 31 and `instr[10:1]` equals 467 (move-to) or 339 (move-from). Any other word with `instr_valid` high produces no register change, `rt_we` low and both interrupt flags low. The reserved bit `instr[0]` has no effect on the result.
- R2: The effective register number is `{instr[15:11], instr[20:16]}`. The defined numbers are 1 and 9 (64-bit scratch), 272 (64-bit supervisor), 18 (32-bit supervisor), 284 (time base low, 32-bit), 285 (time base high, 32-bit) and 313 (64-bit hypervisor-only). Every other number is undefined.
- R3: A permitted move-to a 64-bit register stores all 64 bits of `rs_value`.
- R4: A permitted move-to a 32-bit register stores only `rs_value[31:0]`.
- R5: A permitted move-from raises `rt_we` and drives `rt_idx` with `instr[25:21]` in the same cycle. `rt_value` carries the full value of a 64-bit register, or a 32-bit register's value in bits 31:0 with bits 63:32 at zero. When `rt_we` is low, `rt_idx` and `rt_value` are zero.
- R6: Writing one time base half leaves the other half unchanged.
- R7: When `instr[20]` is 1 (the privileged bit of the field) and `msr_pr` is 1, a recognised instruction raises `int_priv`. This holds whether or not the number is defined. Nothing is written and `rt_we` stays low.
- R8: A recognised access to an undefined number that does not raise `int_priv` raises `int_illegal` instead, with no effect. The two flags are never high together.
- R9: An access to the hypervisor-only register with `msr_hv` = 0 and `msr_pr` = 0 has no effect: no write, `rt_we` low, no interrupt flag.
- R10: Writes happen only on a rising edge with `instr_valid` high and neither flag raised. While `instr_valid` is low, `rt_we`, `int_priv` and `int_illegal` are low.
- R11: A synchronous active-high `rst` clears every special register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Qualifies `instr` and the state inputs this cycle |
| instr | input | 32 | Instruction word; bit 31 is the first bit of the opcode |
| rs_value | input | 64 | Source general register contents for a move-to |
| msr_pr | input | 1 | Problem state bit |
| msr_hv | input | 1 | Hypervisor mode bit |
| rt_we | output | 1 | Destination general register write enable (move-from) |
| rt_idx | output | 5 | Destination general register index |
| rt_value | output | 64 | Value to place in the destination register |
| int_priv | output | 1 | Privileged-instruction program interrupt |
| int_illegal | output | 1 | Illegal-instruction program interrupt |

## Verification
The bound checker watches on every cycle for the relations between the instruction bits, the state bits and the outputs. These are the privileged flag on a problem-state access with the privileged bit set, the two flags never being high together, outputs staying quiet without `instr_valid` or on a foreign opcode, zero upper bits on narrow reads, and register writes happening only without a flag and, for the hypervisor register, only in hypervisor mode. Properties that need register contents carried across cycles can only be shown by the bench's scenarios. These are the full 64-bit versus truncated stores, the independence of the two time base halves, the unchanged value after a denied or ignored access, the swapped-halves numbering, and the clearing by reset.

// File: rtl/spru_pkg.sv
`timescale 1ns/1ps
package spru_pkg;

  localparam logic [5:0] PRIMARY_OP   = 6'd31;
  localparam logic [9:0] XO_MOVE_TO   = 10'd467;
  localparam logic [9:0] XO_MOVE_FROM = 10'd339;

  // effective register numbers
  localparam logic [9:0] SRN_SCR0 = 10'd1;
  localparam logic [9:0] SRN_SCR1 = 10'd9;
  localparam logic [9:0] SRN_SVN  = 10'd18;
  localparam logic [9:0] SRN_SVW  = 10'd272;
  localparam logic [9:0] SRN_TBLO = 10'd284;
  localparam logic [9:0] SRN_TBHI = 10'd285;
  localparam logic [9:0] SRN_HYP  = 10'd313;

  typedef enum logic [2:0] {
    SR_SCR0, SR_SCR1, SR_SVW, SR_SVN, SR_HYP, SR_TBLO, SR_TBHI, SR_NONE
  } sr_id_e;

  localparam int NUM_SR = 7;
  localparam int SLOTS  = 2 ** $bits(sr_id_e);

  typedef enum logic [1:0] { OP_NONE, OP_TO, OP_FROM } op_e;

  function automatic sr_id_e sr_lookup(input logic [9:0] n);
    case (n)
      SRN_SCR0: return SR_SCR0;
      SRN_SCR1: return SR_SCR1;
      SRN_SVW:  return SR_SVW;
      SRN_SVN:  return SR_SVN;
      SRN_HYP:  return SR_HYP;
      SRN_TBLO: return SR_TBLO;
      SRN_TBHI: return SR_TBHI;
      default:  return SR_NONE;
    endcase
  endfunction

  function automatic logic sr_narrow(input int idx);
    return (idx == int'(SR_SVN)) || (idx == int'(SR_TBLO)) || (idx == int'(SR_TBHI));
  endfunction

  function automatic logic sr_hyp(input sr_id_e id);
    return id == SR_HYP;
  endfunction

endpackage

// File: rtl/spru_decode.sv
`timescale 1ns/1ps
module spru_decode
  import spru_pkg::*;
(
  input  logic [31:0] instr,
  output op_e         op,
  output logic [4:0]  gpr,
  output logic [9:0]  srn,
  output logic        priv_field
);

  logic [5:0] primary;
  logic [9:0] xo;
  logic       unused_rsvd;

  assign primary     = instr[31:26];
  assign xo          = instr[10:1];
  assign unused_rsvd = instr[0];
  assign gpr         = instr[25:21];
  // halves of the encoded field are swapped to form the number
  assign srn         = {instr[15:11], instr[20:16]};
  assign priv_field  = instr[20];

  always_comb begin
    op = OP_NONE;
    if (primary == PRIMARY_OP) begin
      if (xo == XO_MOVE_TO)        op = OP_TO;
      else if (xo == XO_MOVE_FROM) op = OP_FROM;
    end
  end

endmodule

// File: rtl/spru_guard.sv
`timescale 1ns/1ps
module spru_guard
  import spru_pkg::*;
(
  input  logic       valid,
  input  op_e        op,
  input  logic [9:0] srn,
  input  logic       priv_field,
  input  logic       msr_pr,
  input  logic       msr_hv,
  output sr_id_e     id,
  output logic       int_priv,
  output logic       int_illegal,
  output logic       do_write,
  output logic       do_read
);

  logic active;
  logic defined;
  logic hyp_block;
  logic granted;

  assign id        = sr_lookup(srn);
  assign defined   = (id != SR_NONE);
  assign active    = valid && (op != OP_NONE);
  assign hyp_block = sr_hyp(id) && !msr_hv;

  assign int_priv    = active && priv_field && msr_pr;
  assign int_illegal = active && !int_priv && !defined;
  assign granted     = active && !int_priv && !int_illegal && !hyp_block;

  assign do_write = granted && (op == OP_TO);
  assign do_read  = granted && (op == OP_FROM);

endmodule

// File: rtl/spru_srbank.sv
`timescale 1ns/1ps
module spru_srbank
  import spru_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  sr_id_e          wr_id,
  input  logic [XLEN-1:0] wr_data,
  input  sr_id_e          rd_id,
  output logic [XLEN-1:0] rd_data
);

  localparam int PAD = XLEN - NARROW;

  logic [XLEN-1:0] view [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g >= NUM_SR) begin : g_empty
      assign view[g] = '0;
    end else if (sr_narrow(g)) begin : g_narrow
      logic [NARROW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                   q <= '0;
        else if (wr_en && (wr_id == sr_id_e'(g)))  q <= wr_data[NARROW-1:0];
      end
      assign view[g] = {{PAD{1'b0}}, q};
    end else begin : g_wide
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                   q <= '0;
        else if (wr_en && (wr_id == sr_id_e'(g)))  q <= wr_data;
      end
      assign view[g] = q;
    end
  end

  assign rd_data = view[rd_id];

endmodule

// File: rtl/spru_unit.sv
`timescale 1ns/1ps
module spru_unit
  import spru_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs_value,
  input  logic            msr_pr,
  input  logic            msr_hv,
  output logic            rt_we,
  output logic [4:0]      rt_idx,
  output logic [XLEN-1:0] rt_value,
  output logic            int_priv,
  output logic            int_illegal
);

  op_e             op;
  logic [4:0]      gpr;
  logic [9:0]      srn;
  logic            priv_field;
  sr_id_e          id;
  logic            do_write;
  logic            do_read;
  logic [XLEN-1:0] rd_data;

  spru_decode u_decode (
    .instr      (instr),
    .op         (op),
    .gpr        (gpr),
    .srn        (srn),
    .priv_field (priv_field)
  );

  spru_guard u_guard (
    .valid       (instr_valid),
    .op          (op),
    .srn         (srn),
    .priv_field  (priv_field),
    .msr_pr      (msr_pr),
    .msr_hv      (msr_hv),
    .id          (id),
    .int_priv    (int_priv),
    .int_illegal (int_illegal),
    .do_write    (do_write),
    .do_read     (do_read)
  );

  spru_srbank #(.XLEN(XLEN), .NARROW(NARROW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (do_write),
    .wr_id   (id),
    .wr_data (rs_value),
    .rd_id   (id),
    .rd_data (rd_data)
  );

  assign rt_we    = do_read;
  assign rt_idx   = do_read ? gpr : 5'd0;
  assign rt_value = do_read ? rd_data : '0;

endmodule

// File: rtl/spru_chk.sv
`timescale 1ns/1ps
module spru_chk
  import spru_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            instr_valid,
  input logic [31:0]     instr,
  input logic            msr_pr,
  input logic            msr_hv,
  input logic            rt_we,
  input logic [XLEN-1:0] rt_value,
  input logic            int_priv,
  input logic            int_illegal,
  input logic            wr_fire
);

  logic       is_move;
  logic [9:0] num;
  logic       narrow_num;

  assign is_move    = (instr[31:26] == 6'd31) &&
                      ((instr[10:1] == 10'd467) || (instr[10:1] == 10'd339));
  assign num        = {instr[15:11], instr[20:16]};
  assign narrow_num = (num == SRN_SVN) || (num == SRN_TBLO) || (num == SRN_TBHI);

  // R1
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !is_move) |-> (!rt_we && !int_priv && !int_illegal && !wr_fire));

  // R5
  narrow_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (rt_we && narrow_num) |-> (rt_value[XLEN-1:NARROW] == '0));

  // R7
  priv_on_pr_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && is_move && instr[20] && msr_pr) |-> (int_priv && !rt_we && !wr_fire));

  // R8
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !(int_priv && int_illegal));

  // R9
  hyp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr_fire || rt_we) && (num == SRN_HYP)) |-> msr_hv);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> (!rt_we && !int_priv && !int_illegal && !wr_fire));

  // R10
  write_clean_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> (instr_valid && !int_priv && !int_illegal));

endmodule

bind spru_unit spru_chk #(.XLEN(XLEN), .NARROW(NARROW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr       (instr),
  .msr_pr      (msr_pr),
  .msr_hv      (msr_hv),
  .rt_we       (rt_we),
  .rt_value    (rt_value),
  .int_priv    (int_priv),
  .int_illegal (int_illegal),
  .wr_fire     (do_write)
);

// File: tb/spru_unit_tb_top.sv
`timescale 1ns/1ps
module spru_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rs_value = '0;
  logic        msr_pr = 1'b0;
  logic        msr_hv = 1'b1;
  logic        rt_we;
  logic [4:0]  rt_idx;
  logic [63:0] rt_value;
  logic        int_priv;
  logic        int_illegal;

  always #10 clk = ~clk;

  spru_unit dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .rs_value(rs_value), .msr_pr(msr_pr), .msr_hv(msr_hv),
    .rt_we(rt_we), .rt_idx(rt_idx), .rt_value(rt_value),
    .int_priv(int_priv), .int_illegal(int_illegal)
  );

  typedef struct {
    logic        we;
    logic [4:0]  idx;
    logic [63:0] val;
    logic        ip;
    logic        il;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] shadow [1024];
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          finished = 0;

  // 0 undefined, 1 wide, 2 narrow, 3 hypervisor wide
  function automatic int kind(input logic [9:0] n);
    case (n)
      10'd1, 10'd9, 10'd272:    return 1;
      10'd18, 10'd284, 10'd285: return 2;
      10'd313:                  return 3;
      default:                  return 0;
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic to, input logic [4:0] g, input logic [9:0] n);
    logic [31:0] w;
    w = '0;
    w[31:26] = 6'd31;
    w[25:21] = g;
    w[20:16] = n[4:0];
    w[15:11] = n[9:5];
    w[10:1]  = to ? 10'd467 : 10'd339;
    return w;
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [63:0] rs, input logic pr,
                       input logic hv, input logic vld, input string tag);
    exp_t       e;
    logic [9:0] n;
    logic       is_to, is_from;
    int         k;
    e.we = 0; e.idx = '0; e.val = '0; e.ip = 0; e.il = 0; e.tag = tag;
    n       = {ins[15:11], ins[20:16]};
    is_to   = (ins[31:26] == 6'd31) && (ins[10:1] == 10'd467);
    is_from = (ins[31:26] == 6'd31) && (ins[10:1] == 10'd339);
    @(posedge clk);
    #2;
    if (vld && (is_to || is_from)) begin
      k = kind(n);
      if (ins[20] && pr)        e.ip = 1;
      else if (k == 0)          e.il = 1;
      else if (k == 3 && !hv)   e.we = 0;
      else if (is_to)           shadow[n] = (k == 2) ? {32'd0, rs[31:0]} : rs;
      else begin
        e.we  = 1;
        e.idx = ins[25:21];
        e.val = shadow[n];
      end
    end
    instr_valid = vld;
    instr       = ins;
    rs_value    = rs;
    msr_pr      = pr;
    msr_hv      = hv;
    sb_q.push_back(e);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #2;
    instr_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    rst = 1'b0;
    for (int i = 0; i < 1024; i++) shadow[i] = '0;
  endtask

  // monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (rt_we !== e.we || rt_idx !== e.idx || rt_value !== e.val ||
          int_priv !== e.ip || int_illegal !== e.il) begin
        n_fails++;
        $display("FAIL %s: actual we=%0b idx=%0d val=%h priv=%0b ill=%0b expected we=%0b idx=%0d val=%h priv=%0b ill=%0b",
                 e.tag, rt_we, rt_idx, rt_value, int_priv, int_illegal,
                 e.we, e.idx, e.val, e.ip, e.il);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) shadow[i] = '0;
    do_reset();

    // R11 every register reads zero after reset
    drive(mk(0, 5'd1, 10'd1),   '0, 0, 1, 1, "R11 scr0 reset");
    drive(mk(0, 5'd1, 10'd9),   '0, 0, 1, 1, "R11 scr1 reset");
    drive(mk(0, 5'd1, 10'd272), '0, 0, 1, 1, "R11 svw reset");
    drive(mk(0, 5'd1, 10'd18),  '0, 0, 1, 1, "R11 svn reset");
    drive(mk(0, 5'd1, 10'd313), '0, 0, 1, 1, "R11 hyp reset");
    drive(mk(0, 5'd1, 10'd284), '0, 0, 1, 1, "R11 tblo reset");
    drive(mk(0, 5'd1, 10'd285), '0, 0, 1, 1, "R11 tbhi reset");

    // R3 R5 wide round trip from problem state on an unprivileged number
    drive(mk(1, 5'd3, 10'd1), 64'hDEAD_BEEF_0123_4567, 1, 0, 1, "R3 write scr0");
    drive(mk(0, 5'd7, 10'd1), '0, 1, 0, 1, "R5 read scr0");
    drive(mk(1, 5'd2, 10'd272), 64'h0123_4567_89AB_CDEF, 0, 0, 1, "R3 write svw");
    drive(mk(0, 5'd30, 10'd272), '0, 0, 0, 1, "R5 read svw");

    // R4 R5 narrow truncation and zero extension
    drive(mk(1, 5'd4, 10'd18), 64'hFFFF_FFFF_89AB_CDEF, 0, 1, 1, "R4 write svn");
    drive(mk(0, 5'd5, 10'd18), '0, 0, 1, 1, "R4 R5 read svn");

    // R6 time base halves independent
    drive(mk(1, 5'd1, 10'd284), 64'h1111_1111_AAAA_0001, 0, 1, 1, "R6 write tblo");
    drive(mk(1, 5'd1, 10'd285), 64'h2222_2222_BBBB_0002, 0, 1, 1, "R6 write tbhi");
    drive(mk(1, 5'd1, 10'd284), 64'h3333_3333_CCCC_0003, 0, 1, 1, "R6 rewrite tblo");
    drive(mk(0, 5'd9, 10'd285), '0, 0, 1, 1, "R6 tbhi unchanged");
    drive(mk(0, 5'd9, 10'd284), '0, 0, 1, 1, "R6 tblo latest");

    // R7 privileged bit with problem state
    drive(mk(1, 5'd2, 10'd272), 64'hBAD0_BAD0_BAD0_BAD0, 1, 0, 1, "R7 write svw denied");
    drive(mk(0, 5'd6, 10'd272), '0, 0, 0, 1, "R7 svw kept");
    drive(mk(0, 5'd6, 10'd272), '0, 1, 0, 1, "R7 read svw denied");
    drive(mk(1, 5'd8, 10'd9), 64'h5555_6666_7777_8888, 1, 0, 1, "R7 unprivileged write scr1");
    drive(mk(0, 5'd8, 10'd9), '0, 1, 0, 1, "R7 unprivileged read scr1");

    // R8 undefined numbers
    drive(mk(1, 5'd1, 10'd5), 64'h1, 0, 0, 1, "R8 undefined write");
    drive(mk(1, 5'd1, 10'd16), 64'h1, 1, 0, 1, "R8 undefined privileged pr1");
    drive(mk(0, 5'd1, 10'd16), '0, 0, 1, 1, "R8 undefined privileged pr0");
    drive(mk(0, 5'd1, 10'd700), '0, 0, 0, 1, "R8 undefined read");

    // R2 swapped halves: 288 is 9 with halves exchanged
    drive(mk(0, 5'd1, 10'd288), '0, 0, 1, 1, "R2 swapped number undefined");
    drive(mk(0, 5'd11, 10'd9), '0, 0, 1, 1, "R2 scr1 by number");

    // R9 hypervisor-only register
    drive(mk(1, 5'd1, 10'd313), 64'hA5A5_A5A5_5A5A_5A5A, 0, 1, 1, "R9 hyp write in hv");
    drive(mk(1, 5'd1, 10'd313), 64'h0F0F_0F0F_0F0F_0F0F, 0, 0, 1, "R9 hyp write ignored");
    drive(mk(0, 5'd1, 10'd313), '0, 0, 0, 1, "R9 hyp read ignored");
    drive(mk(0, 5'd12, 10'd313), '0, 0, 1, 1, "R9 hyp value kept");
    drive(mk(1, 5'd1, 10'd313), 64'h1, 1, 1, 1, "R9 R7 hyp from problem state");

    // R1 decode
    drive(mk(1, 5'd1, 10'd9) ^ 32'h0400_0000, 64'h9, 0, 1, 1, "R1 wrong primary opcode");
    drive(mk(1, 5'd1, 10'd9) ^ 32'h0000_0002, 64'h9, 0, 1, 1, "R1 wrong extended opcode");
    drive(mk(0, 5'd13, 10'd9), '0, 0, 1, 1, "R1 scr1 untouched");
    drive(mk(1, 5'd1, 10'd9) | 32'h1, 64'hCAFE_F00D_1234_5678, 0, 1, 1, "R1 reserved bit set write");
    drive(mk(0, 5'd14, 10'd9) | 32'h1, '0, 0, 1, 1, "R1 reserved bit set read");

    // R10 no effect without instr_valid
    drive(mk(1, 5'd1, 10'd1), 64'h7777_7777_7777_7777, 0, 1, 0, "R10 invalid write");
    drive(mk(0, 5'd1, 10'd1), '0, 0, 1, 0, "R10 invalid read quiet");
    drive(mk(0, 5'd15, 10'd1), '0, 0, 1, 1, "R10 scr0 kept");

    // R11 reset clears state mid-run
    do_reset();
    drive(mk(0, 5'd1, 10'd1),   '0, 0, 1, 1, "R11 scr0 cleared");
    drive(mk(0, 5'd1, 10'd285), '0, 0, 1, 1, "R11 tbhi cleared");
    drive(mk(0, 5'd1, 10'd313), '0, 0, 1, 1, "R11 hyp cleared");

    @(posedge clk);
    #2;
    instr_valid = 1'b0;
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule